// File: doc/BRIEF.md
# Reciprocal Clock Frequency Meter

This block estimates the frequency of one of three on-chip clocks (a fast internal RC clock, a slow internal RC clock or a slow crystal clock) against a reference oscillator of known frequency. Software programs a window length in cycles of the clock being measured and writes a start bit. The block then counts reference-clock cycles for that many measured-clock cycles and stores the count. The measured frequency is the reference frequency times the window length, divided by the count.

The window counter runs on the measured clock. Its begin and end events cross into the reference domain as toggles through two-flop synchronizers. The reference-domain controller has four states. `RS_IDLE` waits for a start and copies the requested source into the active source. `RS_LAUNCH` has sent the start toggle and waits for the begin event. `RS_COUNT` counts reference cycles until the end event. `RS_STORE` moves the count into the result register. The transitions are: idle to launch on a start with a nonzero window; launch to count on the begin event; launch straight to store when the begin and end events arrive in the same cycle; count to store on the end event; store back to idle. The measured-domain counter has two states. `WS_IDLE` goes to `WS_RUN` on a synchronized start. `WS_RUN` returns to `WS_IDLE` once the window's last measured cycle has passed. The register file also holds PLL-reference thresholds, a divider field, a monitor enable bit and three interrupt flags. Each flag is set by an event input and cleared by software.

Top module: `clk_freq_meter`

## Requirements
- R1: After reset the control word reads with select and active source both 0 (fast RC), start bit 23 at 0 and all stored fields at 0. The window register (offset 0x18) reads DUR_RST, and the result (0x04) and the flag word (0x10) read 0.
- R2: Writing 1 to control bit 23 while idle, with a nonzero window, sets bit 23. The bit stays 1 until the count reaches the result register and then clears. A start written while a measurement runs is ignored.
- R3: The result (offset 0x04, low CNT_W bits) is within 3 of the number of reference cycles spanned by the programmed number of measured-clock cycles.
- R4: Control bits [9:8] select the source: 0 is fast RC, 1 is slow RC, 2 is crystal. A write of value 3 leaves the select field unchanged.
- R5: Control bits [17:16] report the source actually driving the window counter. This field follows the select field only while idle and stays frozen during a measurement.
- R6: A start with a window of zero never sets bit 23, and it sets the result to 0 on the next read.
- R7: A count that would exceed CNT_W bits stops at all ones.
- R8: Flag bits at offset 0x10 are 0 for PLL above the high threshold, 1 for PLL below the low threshold and 2 for oscillator below reference. An event input pulse sets its flag. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R9: Offset 0x14 and any offset not listed read 0, and writes to them change no register.
- R10: Offsets 0x08 and 0x0C (high and low thresholds, low CNT_W bits), control bit 0 (monitor enable) and control bits [6:4] (divider) read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference oscillator and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_fast | input | 1 | Fast internal RC clock (source 0) |
| clk_slow | input | 1 | Slow internal RC clock (source 1) |
| clk_xtal | input | 1 | Slow crystal clock (source 2) |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| evt_pll_hi | input | 1 | PLL-above-high-threshold event |
| evt_pll_lo | input | 1 | PLL-below-low-threshold event |
| evt_osc_lo | input | 1 | Oscillator-below-reference event |

## Verification
The measurement runs on each of the three sources, which have different periods and window lengths. A count from the wrong source or with a wrong window scale misses its expected value by far more than the tolerance. A window of zero and a window long enough to overflow the counter exercise the two ends of the count range. A select change written during a measurement shows whether the active source is frozen or follows the request too early.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
    typedef enum logic [1:0] {
        SRC_FAST = 2'd0,
        SRC_SLOW = 2'd1,
        SRC_XTAL = 2'd2
    } src_e;

    typedef enum logic [1:0] {
        RS_IDLE   = 2'd0,
        RS_LAUNCH = 2'd1,
        RS_COUNT  = 2'd2,
        RS_STORE  = 2'd3
    } ref_state_e;

    typedef enum logic {
        WS_IDLE = 1'b0,
        WS_RUN  = 1'b1
    } win_state_e;

    localparam int ADDR_W = 5;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_RES  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_HI   = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_LO   = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_FLAG = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_DUR  = 5'h18;

    localparam int BIT_MON   = 0;
    localparam int DIV_LSB   = 4;
    localparam int DIV_W     = 3;
    localparam int SEL_LSB   = 8;
    localparam int ACT_LSB   = 16;
    localparam int BIT_START = 23;
    localparam int FLAG_N    = 3;
endpackage

// File: rtl/cfm_sync.sv
module cfm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cfm_win_ctr.sv
module cfm_win_ctr
    import cfm_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             mclk,
    input  logic             rst_n,
    input  logic             start_tgl,
    input  logic [CNT_W-1:0] dur,
    output logic             begin_tgl,
    output logic             end_tgl
);
    win_state_e       state, nxt;
    logic             start_s, start_d, start_ev;
    logic [CNT_W-1:0] remain;

    cfm_sync #(.STAGES(2)) u_sync_start (
        .clk(mclk), .rst_n(rst_n), .d(start_tgl), .q(start_s)
    );

    assign start_ev = start_s ^ start_d;

    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) state <= WS_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            WS_IDLE: if (start_ev) nxt = WS_RUN;
            WS_RUN:  if (remain <= CNT_W'(1)) nxt = WS_IDLE;
        endcase
    end

    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) begin
            start_d   <= 1'b0;
            begin_tgl <= 1'b0;
            end_tgl   <= 1'b0;
            remain    <= '0;
        end else begin
            start_d <= start_s;
            unique case (state)
                WS_IDLE: begin
                    if (start_ev) begin
                        begin_tgl <= ~begin_tgl;
                        remain    <= dur;
                    end
                end
                WS_RUN: begin
                    if (remain <= CNT_W'(1)) end_tgl <= ~end_tgl;
                    else                     remain  <= remain - CNT_W'(1);
                end
            endcase
        end
    end
endmodule

// File: rtl/cfm_ref_ctrl.sv
module cfm_ref_ctrl
    import cfm_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_wr,
    input  logic [CNT_W-1:0] dur_in,
    input  logic [1:0]       sel_req,
    input  logic             begin_tgl_m,
    input  logic             end_tgl_m,
    output logic             start_tgl,
    output logic [CNT_W-1:0] dur_hold,
    output logic [1:0]       active_sel,
    output logic             busy,
    output logic [CNT_W-1:0] result
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    ref_state_e       state, nxt;
    logic             begin_s, begin_d, begin_ev;
    logic             end_s, end_d, end_ev;
    logic             go, zero_go;
    logic [CNT_W-1:0] cnt;

    cfm_sync #(.STAGES(2)) u_sync_begin (
        .clk(clk), .rst_n(rst_n), .d(begin_tgl_m), .q(begin_s)
    );
    cfm_sync #(.STAGES(2)) u_sync_end (
        .clk(clk), .rst_n(rst_n), .d(end_tgl_m), .q(end_s)
    );

    assign begin_ev = begin_s ^ begin_d;
    assign end_ev   = end_s ^ end_d;
    assign go       = start_wr && (dur_in != '0);
    assign zero_go  = start_wr && (dur_in == '0);
    assign busy     = (state != RS_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RS_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RS_IDLE:   if (go) nxt = RS_LAUNCH;
            RS_LAUNCH: begin
                if (begin_ev && end_ev) nxt = RS_STORE;
                else if (begin_ev)      nxt = RS_COUNT;
            end
            RS_COUNT:  if (end_ev) nxt = RS_STORE;
            RS_STORE:  nxt = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            begin_d    <= 1'b0;
            end_d      <= 1'b0;
            start_tgl  <= 1'b0;
            dur_hold   <= '0;
            active_sel <= SRC_FAST;
            cnt        <= '0;
            result     <= '0;
        end else begin
            begin_d <= begin_s;
            end_d   <= end_s;
            unique case (state)
                RS_IDLE: begin
                    active_sel <= sel_req;
                    if (go) begin
                        start_tgl <= ~start_tgl;
                        dur_hold  <= dur_in;
                        cnt       <= '0;
                    end else if (zero_go) begin
                        result <= '0;
                    end
                end
                RS_LAUNCH: cnt <= '0;
                RS_COUNT: begin
                    if (cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
                end
                RS_STORE: result <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/cfm_regs.sv
module cfm_regs
    import cfm_pkg::*;
#(
    parameter int CNT_W   = 20,
    parameter int DUR_RST = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              busy,
    input  logic [1:0]        active_sel,
    input  logic [CNT_W-1:0]  result,
    input  logic [FLAG_N-1:0] evt,
    output logic              start_wr,
    output logic [1:0]        sel_req,
    output logic [CNT_W-1:0]  dur,
    output logic [FLAG_N-1:0] flags
);
    localparam int PAD_W = 32 - CNT_W;

    logic             mon_en;
    logic [DIV_W-1:0] rc_div;
    logic [CNT_W-1:0] hi_ref, lo_ref;
    logic             wr_ctrl, wr_flag;
    logic [1:0]       sel_wr;

    assign wr_ctrl  = wr && (addr == OFS_CTRL);
    assign wr_flag  = wr && (addr == OFS_FLAG);
    assign sel_wr   = wdata[SEL_LSB +: 2];
    assign start_wr = wr_ctrl && wdata[BIT_START] && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_en  <= 1'b0;
            rc_div  <= '0;
            sel_req <= SRC_FAST;
            hi_ref  <= '0;
            lo_ref  <= '0;
            dur     <= CNT_W'(DUR_RST);
        end else if (wr) begin
            unique case (addr)
                OFS_CTRL: begin
                    mon_en <= wdata[BIT_MON];
                    rc_div <= wdata[DIV_LSB +: DIV_W];
                    if (sel_wr != 2'd3) sel_req <= sel_wr;
                end
                OFS_HI:  hi_ref <= wdata[CNT_W-1:0];
                OFS_LO:  lo_ref <= wdata[CNT_W-1:0];
                OFS_DUR: dur    <= wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    generate
        for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                  flags[i] <= 1'b0;
                else if (evt[i])             flags[i] <= 1'b1;
                else if (wr_flag && wdata[i]) flags[i] <= 1'b0;
            end
        end
    endgenerate

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFS_CTRL: begin
                rdata[BIT_MON]            = mon_en;
                rdata[DIV_LSB +: DIV_W]   = rc_div;
                rdata[SEL_LSB +: 2]       = sel_req;
                rdata[ACT_LSB +: 2]       = active_sel;
                rdata[BIT_START]          = busy;
            end
            OFS_RES:  rdata = {{PAD_W{1'b0}}, result};
            OFS_HI:   rdata = {{PAD_W{1'b0}}, hi_ref};
            OFS_LO:   rdata = {{PAD_W{1'b0}}, lo_ref};
            OFS_FLAG: rdata[FLAG_N-1:0] = flags;
            OFS_DUR:  rdata = {{PAD_W{1'b0}}, dur};
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/clk_freq_meter.sv
module clk_freq_meter
    import cfm_pkg::*;
#(
    parameter int CNT_W   = 20,
    parameter int DUR_RST = 256
) (
    input  logic        ref_clk,
    input  logic        rst_n,
    input  logic        clk_fast,
    input  logic        clk_slow,
    input  logic        clk_xtal,
    input  logic [4:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        evt_pll_hi,
    input  logic        evt_pll_lo,
    input  logic        evt_osc_lo
);
    logic             start_wr, busy, start_tgl, begin_tgl, end_tgl, meas_clk;
    logic [1:0]       sel_req, active_sel;
    logic [CNT_W-1:0] dur, dur_hold, result;
    logic [FLAG_N-1:0] flags, evt;

    assign evt = {evt_osc_lo, evt_pll_lo, evt_pll_hi};

    always_comb begin
        unique case (active_sel)
            SRC_SLOW: meas_clk = clk_slow;
            SRC_XTAL: meas_clk = clk_xtal;
            default:  meas_clk = clk_fast;
        endcase
    end

    cfm_regs #(.CNT_W(CNT_W), .DUR_RST(DUR_RST)) u_regs (
        .clk(ref_clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
        .wdata(bus_wdata), .rdata(bus_rdata), .busy(busy),
        .active_sel(active_sel), .result(result), .evt(evt),
        .start_wr(start_wr), .sel_req(sel_req), .dur(dur), .flags(flags)
    );

    cfm_ref_ctrl #(.CNT_W(CNT_W)) u_ref (
        .clk(ref_clk), .rst_n(rst_n), .start_wr(start_wr), .dur_in(dur),
        .sel_req(sel_req), .begin_tgl_m(begin_tgl), .end_tgl_m(end_tgl),
        .start_tgl(start_tgl), .dur_hold(dur_hold), .active_sel(active_sel),
        .busy(busy), .result(result)
    );

    cfm_win_ctr #(.CNT_W(CNT_W)) u_win (
        .mclk(meas_clk), .rst_n(rst_n), .start_tgl(start_tgl),
        .dur(dur_hold), .begin_tgl(begin_tgl), .end_tgl(end_tgl)
    );
endmodule

// File: rtl/cfm_checker.sv
module cfm_checker #(
    parameter int CNT_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             start_wr,
    input logic             dur_zero,
    input logic [1:0]       active_sel,
    input logic [2:0]       flags,
    input logic [2:0]       evt,
    input logic [CNT_W-1:0] result
);
    a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && !dur_zero && !busy) |=> busy);

    a_r2_result_moves_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> !busy);

    a_r4_active_legal: assert property (@(posedge clk) disable iff (!rst_n)
        active_sel != 2'd3);

    a_r5_active_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(active_sel));

    a_r6_zero_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && dur_zero && !busy) |=> !busy);

    a_r8_flag_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & ~$past(flags) & ~$past(evt)) == 3'b000);
endmodule

bind clk_freq_meter cfm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(ref_clk), .rst_n(rst_n), .busy(busy), .start_wr(start_wr),
    .dur_zero(dur == '0), .active_sel(active_sel), .flags(flags),
    .evt(evt), .result(result)
);

// File: tb/clk_freq_meter_test.sv
module clk_freq_meter_test;
    localparam int CW = 12;
    localparam int DR = 64;

    logic        ref_clk = 0, rst_n = 0;
    logic        clk_fast = 0, clk_slow = 0, clk_xtal = 0;
    logic [4:0]  bus_addr = 0;
    logic        bus_wr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        evt_pll_hi = 0, evt_pll_lo = 0, evt_osc_lo = 0;
    int total = 0, bad = 0;

    clk_freq_meter #(.CNT_W(CW), .DUR_RST(DR)) uut (
        .ref_clk(ref_clk), .rst_n(rst_n), .clk_fast(clk_fast),
        .clk_slow(clk_slow), .clk_xtal(clk_xtal), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_pll_hi(evt_pll_hi), .evt_pll_lo(evt_pll_lo), .evt_osc_lo(evt_osc_lo)
    );

    always #5   ref_clk  = ~ref_clk;
    always #20  clk_fast = ~clk_fast;
    always #85  clk_slow = ~clk_slow;
    always #165 clk_xtal = ~clk_xtal;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic check_near(input string tag, input int got, input int exp);
        total++;
        if (got < exp - 3 || got > exp + 3) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge ref_clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge ref_clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge ref_clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle(output bit ok);
        logic [31:0] v;
        ok = 0;
        for (int i = 0; i < 20000; i++) begin
            rd(5'h00, v);
            if (!v[23]) begin ok = 1; break; end
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(5'h00, v); check("R1 ctrl", v, 32'h0);
        rd(5'h18, v); check("R1 window", v, DR);
        rd(5'h04, v); check("R1 result", v, 0);
        rd(5'h10, v); check("R1 flags", v, 0);
    endtask

    task automatic t_measure(input string tag, input int src, input int md, input int per_ns);
        logic [31:0] v;
        bit ok;
        wr(5'h00, src << 8);
        repeat (2) @(negedge ref_clk);
        wr(5'h18, md);
        wr(5'h00, (src << 8) | (1 << 23));
        rd(5'h00, v); check({tag, " R2 busy"}, v[23], 1);
        check({tag, " R5 active"}, v[17:16], src);
        wait_idle(ok); check({tag, " R2 clears"}, ok, 1);
        rd(5'h04, v);
        check_near({tag, " R3 count"}, int'(v), md * per_ns / 10);
    endtask

    task automatic t_select_rules;
        logic [31:0] v;
        bit ok;
        wr(5'h00, 2 << 8);
        wr(5'h00, 3 << 8);
        rd(5'h00, v); check("R4 sel 3 ignored", v[9:8], 2);
        wr(5'h00, 0);
        repeat (2) @(negedge ref_clk);
        wr(5'h18, 200);
        wr(5'h00, 1 << 23);
        wr(5'h00, (1 << 8) | (1 << 23));
        rd(5'h00, v);
        check("R5 frozen active", v[17:16], 0);
        check("R4 request stored", v[9:8], 1);
        wait_idle(ok);
        rd(5'h04, v); check_near("R2 restart ignored", int'(v), 800);
        rd(5'h00, v); check("R5 follows when idle", v[17:16], 1);
    endtask

    task automatic t_zero;
        logic [31:0] v;
        wr(5'h18, 0);
        wr(5'h00, 1 << 23);
        rd(5'h00, v); check("R6 start clear", v[23], 0);
        rd(5'h04, v); check("R6 result zero", v, 0);
    endtask

    task automatic t_saturate;
        logic [31:0] v;
        bit ok;
        wr(5'h00, 2 << 8);
        repeat (2) @(negedge ref_clk);
        wr(5'h18, 200);
        wr(5'h00, (2 << 8) | (1 << 23));
        wait_idle(ok);
        rd(5'h04, v); check("R7 saturate", v, (1 << CW) - 1);
    endtask

    task automatic t_flags;
        logic [31:0] v;
        @(negedge ref_clk); evt_pll_hi = 1; evt_osc_lo = 1;
        @(negedge ref_clk); evt_pll_hi = 0; evt_osc_lo = 0;
        rd(5'h10, v); check("R8 set", v, 32'h5);
        wr(5'h10, 32'h0);
        rd(5'h10, v); check("R8 write 0 keeps", v, 32'h5);
        wr(5'h10, 32'h1);
        rd(5'h10, v); check("R8 w1c", v, 32'h4);
        @(negedge ref_clk); evt_pll_lo = 1;
        @(negedge ref_clk); evt_pll_lo = 0;
        rd(5'h10, v); check("R8 low flag", v, 32'h6);
    endtask

    task automatic t_reserved_storage;
        logic [31:0] v;
        wr(5'h08, 32'hABC);
        wr(5'h0C, 32'h123);
        wr(5'h00, 32'h51);
        wr(5'h14, 32'hFFFF_FFFF);
        wr(5'h1C, 32'hFFFF_FFFF);
        rd(5'h14, v); check("R9 reserved read", v, 0);
        rd(5'h1C, v); check("R9 unmapped read", v, 0);
        rd(5'h08, v); check("R10 high thr", v, 32'hABC);
        rd(5'h0C, v); check("R10 low thr", v, 32'h123);
        rd(5'h00, v); check("R10 mon and div", v[6:0], 7'h51);
        rd(5'h18, v); check("R9 window kept", v, 200);
    endtask

    initial begin
        #2000000;
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge ref_clk);
        rst_n = 1;
        t_reset();
        t_measure("fast", 0, 100, 40);
        t_measure("slow", 1, 50, 170);
        t_measure("xtal", 2, 10, 330);
        t_zero();
        t_select_rules();
        t_saturate();
        t_flags();
        t_reserved_storage();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule